// File: doc/BRIEF.md
# Host Data Bus Buffer Interface

This block sits between an external host bus and the local processor of a small keyboard-style controller. It keeps two separate byte registers. One holds a byte written by the host until the local processor takes it. The other holds a byte written by the local processor until the host collects it. An 8-bit status byte lets both sides see the state of the exchange: two buffer-full flags, two system flags and four user bits that the local side writes.

The host uses active-low chip select, read and write strobes and one address bit. With the address bit low, the host moves data. With it high, a write is treated as a command and a read returns the status byte. A three-state machine tracks each host access:
- `BUS_IDLE` moves to `BUS_WRITE` when a selected write strobe goes low. It moves to `BUS_READ` when a selected read strobe goes low and the write strobe is high.
- `BUS_WRITE` returns to `BUS_IDLE` when the write strobe goes high.
- `BUS_READ` returns to `BUS_IDLE` when the read strobe goes high.

Each strobe therefore counts as exactly one access, however long it is held. After the local side enables DMA mode, a DMA acknowledge input also selects the block. Such an access is treated as a data access with the address bit low.

Top module: `hostbuf_if`

## Requirements
- R1: After reset, `cpu_status` is 0x00, `host_dout_en` is 0 and DMA mode is off.
- R2: A selected host write loads `host_din` into the input buffer. From the next cycle, `cpu_ibuf` shows the byte, status bit 1 (input full) is 1, and status bit 3 (F1) equals the effective address bit.
- R3: A `cpu_ibuf_rd` pulse clears status bit 1 in the next cycle. If a host write is accepted in the same cycle, the bit stays 1.
- R4: A `cpu_obuf_wr` pulse loads the output buffer and sets status bit 0 (output full). A host read with the address bit low returns that byte on `host_dout`, with `host_dout_en` high, from the cycle after the strobe is seen until the cycle after it is released. Status bit 0 clears in the cycle after the release. A `cpu_obuf_wr` in the release cycle wins, and the bit stays 1.
- R5: A host read with the address bit high returns the status byte {user[3:0], F1, F0, input full, output full}, as it stood when the strobe was seen, and leaves both buffer-full flags unchanged.
- R6: `cpu_f0_wr`, `cpu_f1_wr` and `cpu_usr_wr` update status bit 2, bit 3 and bits 7:4 in the next cycle. A host write in the same cycle sets bit 3, and the host value wins over the local one.
- R7: A write strobe held low for many cycles loads only the value present when it was first seen. If read and write strobes are both low when an access starts, the access is a write.
- R8: Before `cpu_dma_en` is pulsed, `host_dack_n` has no effect. Once enabled, DMA mode lasts until reset. In that mode `host_dack_n` low selects the block, and `host_a0` is taken as 0.
- R9: With `host_cs_n` high and no active DMA acknowledge, host strobes change neither the buffers nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_dack_n | input | 1 | DMA acknowledge, active low, used as a select in DMA mode |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Address bit: 0 = data, 1 = command/status |
| host_din | input | 8 | Byte written by the host |
| host_dout | output | 8 | Byte returned to the host |
| host_dout_en | output | 1 | High while `host_dout` should be driven |
| cpu_ibuf_rd | input | 1 | Local read of the input buffer (clears input full) |
| cpu_ibuf | output | 8 | Input buffer contents |
| cpu_obuf_wr | input | 1 | Local write of the output buffer |
| cpu_obuf_din | input | 8 | Byte for the output buffer |
| cpu_f0_wr | input | 1 | Write strobe for F0 |
| cpu_f0_val | input | 1 | New value for F0 |
| cpu_f1_wr | input | 1 | Write strobe for F1 |
| cpu_f1_val | input | 1 | New value for F1 |
| cpu_usr_wr | input | 1 | Write strobe for the user status bits |
| cpu_usr_din | input | 4 | New user status bits |
| cpu_dma_en | input | 1 | Pulse that enables DMA mode until reset |
| cpu_status | output | 8 | Current status byte |

## Verification
All register effects appear one clock after the edge that samples the stimulus. A write, a local buffer read, a local output write or a flag write is visible one cycle later. Read data and `host_dout_en` show up one cycle after the read strobe is first seen. The output-full flag drops one cycle after the strobe goes high. The bench drives on falling edges and checks on the following falling edges. A scoreboard queue holds each expected read byte and pops it on the falling edge where `host_dout_en` is first seen high. Same-edge conflicts are driven on one falling edge so that both events meet at one rising edge.

// File: rtl/hostbuf_pkg.sv
package hostbuf_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_t;

    // Status byte layout, fixed because the host decodes it
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int F0_BIT  = 2;
    localparam int F1_BIT  = 3;
    localparam int USR_LSB = 4;
endpackage

// File: rtl/hostbuf_sel.sv
module hostbuf_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_dma_en,
    input  logic host_cs_n,
    input  logic host_dack_n,
    input  logic host_a0,
    output logic sel,
    output logic a0_eff,
    output logic dma_mode
);
    logic dack_act;

    always_ff @(posedge clk) begin
        if (!rst_n)          dma_mode <= 1'b0;
        else if (cpu_dma_en) dma_mode <= 1'b1;
    end

    always_comb begin
        dack_act = dma_mode && !host_dack_n;
        sel      = !host_cs_n || dack_act;
        a0_eff   = dack_act ? 1'b0 : host_a0;
    end
endmodule

// File: rtl/hostbuf_fsm.sv
module hostbuf_fsm
    import hostbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_go,
    output logic rd_go,
    output logic rd_end,
    output logic dout_en
);
    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (sel && !wr_n)      state_d = BUS_WRITE;
                else if (sel && !rd_n) state_d = BUS_READ;
            end
            BUS_WRITE: if (wr_n) state_d = BUS_IDLE;
            BUS_READ:  if (rd_n) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        rd_end  = 1'b0;
        dout_en = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                wr_go = sel && !wr_n;
                rd_go = sel && wr_n && !rd_n;
            end
            BUS_WRITE: ;
            BUS_READ: begin
                dout_en = 1'b1;
                rd_end  = rd_n;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hostbuf_regs.sv
module hostbuf_regs
    import hostbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int USR_W = DATA_W - USR_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic              rd_end,
    input  logic              a0_eff,
    input  logic [DATA_W-1:0] host_din,
    input  logic              cpu_ibuf_rd,
    input  logic              cpu_obuf_wr,
    input  logic [DATA_W-1:0] cpu_obuf_din,
    input  logic              cpu_f0_wr,
    input  logic              cpu_f0_val,
    input  logic              cpu_f1_wr,
    input  logic              cpu_f1_val,
    input  logic              cpu_usr_wr,
    input  logic [USR_W-1:0]  cpu_usr_din,
    output logic [DATA_W-1:0] ibuf,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] dout,
    output logic              rd_is_data
);
    logic [DATA_W-1:0] obuf;
    logic              ibf, obf, f0, f1;
    logic [USR_W-1:0]  usr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf <= '0;
            ibf  <= 1'b0;
            f1   <= 1'b0;
        end else if (wr_go) begin
            ibuf <= host_din;
            ibf  <= 1'b1;
            f1   <= a0_eff;
        end else begin
            if (cpu_ibuf_rd) ibf <= 1'b0;
            if (cpu_f1_wr)   f1  <= cpu_f1_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obuf <= '0;
            obf  <= 1'b0;
        end else if (cpu_obuf_wr) begin
            obuf <= cpu_obuf_din;
            obf  <= 1'b1;
        end else if (rd_end && rd_is_data) begin
            obf  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f0  <= 1'b0;
            usr <= '0;
        end else begin
            if (cpu_f0_wr)  f0  <= cpu_f0_val;
            if (cpu_usr_wr) usr <= cpu_usr_din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            rd_is_data <= 1'b0;
        end else if (rd_go) begin
            dout       <= a0_eff ? status : obuf;
            rd_is_data <= !a0_eff;
        end
    end

    always_comb begin
        status[OBF_BIT] = obf;
        status[IBF_BIT] = ibf;
        status[F0_BIT]  = f0;
        status[F1_BIT]  = f1;
    end

    for (genvar g = 0; g < USR_W; g++) begin : g_usr
        assign status[USR_LSB+g] = usr[g];
    end
endmodule

// File: rtl/hostbuf_if.sv
module hostbuf_if
    import hostbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_dack_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_dout_en,
    input  logic              cpu_ibuf_rd,
    output logic [DATA_W-1:0] cpu_ibuf,
    input  logic              cpu_obuf_wr,
    input  logic [DATA_W-1:0] cpu_obuf_din,
    input  logic              cpu_f0_wr,
    input  logic              cpu_f0_val,
    input  logic              cpu_f1_wr,
    input  logic              cpu_f1_val,
    input  logic              cpu_usr_wr,
    input  logic [DATA_W-5:0] cpu_usr_din,
    input  logic              cpu_dma_en,
    output logic [DATA_W-1:0] cpu_status
);
    logic sel, a0_eff, dma_mode;
    logic wr_go, rd_go, rd_end, rd_is_data;

    hostbuf_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_dma_en (cpu_dma_en),
        .host_cs_n  (host_cs_n),
        .host_dack_n(host_dack_n),
        .host_a0    (host_a0),
        .sel        (sel),
        .a0_eff     (a0_eff),
        .dma_mode   (dma_mode)
    );

    hostbuf_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .rd_n   (host_rd_n),
        .wr_n   (host_wr_n),
        .wr_go  (wr_go),
        .rd_go  (rd_go),
        .rd_end (rd_end),
        .dout_en(host_dout_en)
    );

    hostbuf_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_go       (wr_go),
        .rd_go       (rd_go),
        .rd_end      (rd_end),
        .a0_eff      (a0_eff),
        .host_din    (host_din),
        .cpu_ibuf_rd (cpu_ibuf_rd),
        .cpu_obuf_wr (cpu_obuf_wr),
        .cpu_obuf_din(cpu_obuf_din),
        .cpu_f0_wr   (cpu_f0_wr),
        .cpu_f0_val  (cpu_f0_val),
        .cpu_f1_wr   (cpu_f1_wr),
        .cpu_f1_val  (cpu_f1_val),
        .cpu_usr_wr  (cpu_usr_wr),
        .cpu_usr_din (cpu_usr_din),
        .ibuf        (cpu_ibuf),
        .status      (cpu_status),
        .dout        (host_dout),
        .rd_is_data  (rd_is_data)
    );
endmodule

// File: rtl/hostbuf_if_chk.sv
module hostbuf_if_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_go,
    input logic              rd_go,
    input logic              rd_end,
    input logic              rd_is_data,
    input logic              cpu_ibuf_rd,
    input logic              cpu_obuf_wr,
    input logic [DATA_W-1:0] cpu_status,
    input logic              dma_mode,
    input logic              host_dout_en
);
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (cpu_status == '0 && !host_dout_en && !dma_mode));
    p_wr_sets_ibf_r2: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> cpu_status[1]);
    p_ibuf_rd_clears_r3: assert property (@(posedge clk) disable iff (!rst_n) (cpu_ibuf_rd && !wr_go) |=> !cpu_status[1]);
    p_obuf_wr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n) cpu_obuf_wr |=> cpu_status[0]);
    p_obf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n) (rd_end && rd_is_data && !cpu_obuf_wr) |=> !cpu_status[0]);
    p_status_rd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n) (rd_end && !rd_is_data && !cpu_obuf_wr && !cpu_ibuf_rd) |=> $stable(cpu_status[1:0]));
    p_one_access_r7: assert property (@(posedge clk) disable iff (!rst_n) !(wr_go && rd_go));
    p_rd_drives_r4: assert property (@(posedge clk) disable iff (!rst_n) rd_go |=> host_dout_en);
    p_dma_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) dma_mode |=> dma_mode);
endmodule

bind hostbuf_if hostbuf_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_go       (wr_go),
    .rd_go       (rd_go),
    .rd_end      (rd_end),
    .rd_is_data  (rd_is_data),
    .cpu_ibuf_rd (cpu_ibuf_rd),
    .cpu_obuf_wr (cpu_obuf_wr),
    .cpu_status  (cpu_status),
    .dma_mode    (dma_mode),
    .host_dout_en(host_dout_en)
);

// File: tb/hostbuf_if_tb.sv
`timescale 1ns/1ps
module hostbuf_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1, host_dack_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_dout_en;
    logic       cpu_ibuf_rd = 1'b0;
    logic [7:0] cpu_ibuf;
    logic       cpu_obuf_wr = 1'b0;
    logic [7:0] cpu_obuf_din = '0;
    logic       cpu_f0_wr = 1'b0, cpu_f0_val = 1'b0, cpu_f1_wr = 1'b0, cpu_f1_val = 1'b0;
    logic       cpu_usr_wr = 1'b0;
    logic [3:0] cpu_usr_din = '0;
    logic       cpu_dma_en = 1'b0;
    logic [7:0] cpu_status;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       en_prev = 1'b0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    hostbuf_if u_dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_dack_n(host_dack_n),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_a0(host_a0), .host_din(host_din),
        .host_dout(host_dout), .host_dout_en(host_dout_en), .cpu_ibuf_rd(cpu_ibuf_rd),
        .cpu_ibuf(cpu_ibuf), .cpu_obuf_wr(cpu_obuf_wr), .cpu_obuf_din(cpu_obuf_din),
        .cpu_f0_wr(cpu_f0_wr), .cpu_f0_val(cpu_f0_val), .cpu_f1_wr(cpu_f1_wr),
        .cpu_f1_val(cpu_f1_val), .cpu_usr_wr(cpu_usr_wr), .cpu_usr_din(cpu_usr_din),
        .cpu_dma_en(cpu_dma_en), .cpu_status(cpu_status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected byte when a read result appears
    always @(negedge clk) begin
        if (host_dout_en && !en_prev) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4: unexpected read data actual %02h expected none", host_dout);
            end else begin
                check(tag_q.pop_front(), host_dout, exp_q.pop_front());
            end
        end
        en_prev <= host_dout_en;
    end

    task automatic host_write(input logic a0, input logic dack, input logic [7:0] d);
        @(negedge clk);
        host_cs_n = dack; host_dack_n = !dack; host_a0 = a0; host_din = d; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1; host_dack_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_read(input logic a0, input logic dack, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_cs_n = dack; host_dack_n = !dack; host_a0 = a0; host_rd_n = 1'b0;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = 1'b1; host_dack_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cpu_obuf(input logic [7:0] d);
        @(negedge clk);
        cpu_obuf_wr = 1'b1; cpu_obuf_din = d;
        @(negedge clk);
        cpu_obuf_wr = 1'b0;
    endtask

    task automatic cpu_take();
        @(negedge clk);
        cpu_ibuf_rd = 1'b1;
        @(negedge clk);
        cpu_ibuf_rd = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", cpu_status, 8'h00);
        check("R1 dout_en", {7'd0, host_dout_en}, 8'h00);

        host_write(1'b0, 1'b0, 8'h5A);
        check("R2 ibuf", cpu_ibuf, 8'h5A);
        check("R2 status data", cpu_status, 8'h02);
        host_write(1'b1, 1'b0, 8'hC3);
        check("R2 ibuf cmd", cpu_ibuf, 8'hC3);
        check("R2 status cmd", cpu_status, 8'h0A);

        cpu_take();
        check("R3 ibf clear", cpu_status, 8'h08);

        host_read(1'b1, 1'b0, 8'h08, "R5 status read");
        check("R5 flags kept", cpu_status, 8'h08);

        cpu_obuf(8'h96);
        check("R4 obf set", cpu_status, 8'h09);
        host_read(1'b1, 1'b0, 8'h09, "R5 status read obf");
        check("R5 obf kept", cpu_status, 8'h09);
        host_read(1'b0, 1'b0, 8'h96, "R4 data read");
        check("R4 obf cleared", cpu_status, 8'h08);

        @(negedge clk);
        cpu_f0_wr = 1'b1; cpu_f0_val = 1'b1; cpu_f1_wr = 1'b1; cpu_f1_val = 1'b0;
        cpu_usr_wr = 1'b1; cpu_usr_din = 4'hA;
        @(negedge clk);
        cpu_f0_wr = 1'b0; cpu_f1_wr = 1'b0; cpu_usr_wr = 1'b0;
        check("R6 flags", cpu_status, 8'hA4);

        // R7: long write strobe, data changes while held; both strobes low
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b0; host_din = 8'h11; host_wr_n = 1'b0; host_rd_n = 1'b0;
        @(negedge clk);
        host_din = 8'h22;
        repeat (4) @(negedge clk);
        check("R7 no read on both strobes", {7'd0, host_dout_en}, 8'h00);
        host_wr_n = 1'b1; host_rd_n = 1'b1; host_cs_n = 1'b1;
        @(negedge clk);
        check("R7 first value", cpu_ibuf, 8'h11);
        check("R7 status", cpu_status, 8'hA6);
        cpu_take();
        check("R3 take again", cpu_status, 8'hA4);

        // R9 and R8: unselected strobes and inactive DMA acknowledge
        host_write(1'b0, 1'b1, 8'hEE);
        check("R8 dack ignored before enable", cpu_status, 8'hA4);
        @(negedge clk);
        host_din = 8'hDD; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
        check("R9 unselected ibuf", cpu_ibuf, 8'h11);
        check("R9 unselected status", cpu_status, 8'hA4);

        @(negedge clk);
        cpu_dma_en = 1'b1;
        @(negedge clk);
        cpu_dma_en = 1'b0;
        host_write(1'b1, 1'b1, 8'h77);
        check("R8 dack write ibuf", cpu_ibuf, 8'h77);
        check("R8 dack a0 forced low", cpu_status, 8'hA6);
        cpu_obuf(8'h3C);
        host_read(1'b1, 1'b1, 8'h3C, "R8 dack read data");
        check("R8 dack read clears obf", cpu_status, 8'hA6);

        // Same-edge conflicts: host write vs local take and local F1 write
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b1; host_din = 8'h44; host_wr_n = 1'b0;
        cpu_ibuf_rd = 1'b1; cpu_f1_wr = 1'b1; cpu_f1_val = 1'b0;
        @(negedge clk);
        cpu_ibuf_rd = 1'b0; cpu_f1_wr = 1'b0; host_wr_n = 1'b1; host_cs_n = 1'b1;
        @(negedge clk);
        check("R3 host write wins ibf", cpu_status, 8'hAE);
        check("R6 host F1 wins", cpu_ibuf, 8'h44);

        // R4: local output write in the read release cycle keeps obf set
        cpu_obuf(8'h55);
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b0; host_rd_n = 1'b0;
        exp_q.push_back(8'h55); tag_q.push_back("R4 data before overwrite");
        @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        cpu_obuf_wr = 1'b1; cpu_obuf_din = 8'h66;
        @(negedge clk);
        cpu_obuf_wr = 1'b0;
        check("R4 local write wins", cpu_status, 8'hAF);
        host_read(1'b0, 1'b0, 8'h66, "R4 new data");
        check("R4 obf after read", cpu_status, 8'hAE);

        // R8: reset ends DMA mode
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset again", cpu_status, 8'h00);
        host_write(1'b0, 1'b1, 8'h99);
        check("R8 dma off after reset", cpu_status, 8'h00);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R4: reads outstanding actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule